// File: doc/BRIEF.md
# Clock Frequency Select Controller

This block is the decision logic in front of a programmable clock synthesizer. It picks which divider settings (a feedback value N, a reference value M and a five-bit ratio/gear code) are presented to the PLL and the output dividers. The settings come from one of three places: a fixed table indexed by a five-bit code, a pair of programmed N/M values, or a pair of programmed recovery N/M values. The five-bit code is taken either from strap pins captured once after reset or from a programmed select field.

Software programs the block through a plain address/data/write-enable port. Every accepted configuration write requests a reload of the active settings. A hold input groups several writes into one transfer so that a multi-register update produces a single reload when the transfer ends. A watchdog, once enabled, starts counting after each change of the active settings. If software does not intervene before it expires, the block switches to a recovery setting by itself and raises a sticky flag.

Top module: `clkfs_ctrl`

## Requirements
- R1: While reset is held, act_n, act_m, act_code, load_stb and wd_timeout are all 0. The strap pins are captured on the first clock edge after reset is released, and a reload follows on the next edge.
- R2: With the programmable enable (ctrl bit 0) and the override (ctrl bit 1) both 0, act_code equals the captured strap code, act_n = 64 + 2*code and act_m = 24.
- R3: With the programmable enable 0 and the override 1, act_code equals the select field (address 1, bits 4:0), and N/M come from the same table indexed by that field.
- R4: With the programmable enable 1, act_n and act_m come from the programmed N (address 2) and M (address 3, bits 6:0). act_code is the select field when the override is 1 and the strap code otherwise.
- R5: A write to any address from 0 to 5 requests a reload. The active outputs are updated on the edge after the write. load_stb is high for exactly that one cycle and only if the active N, M or code value changed. The outputs never change without it.
- R6: While wr_hold is high, writes update the registers but no reload takes place and load_stb stays 0. The first edge with wr_hold low performs a single reload that covers all of those writes.
- R7: With the watchdog enable (ctrl bit 2) at 1, a load strobe starts the watchdog. wd_timeout rises (WD_RELOAD+1)*WD_PRESCALE+1 cycles after the strobe cycle and stays high. With the enable at 0, the watchdog is stopped and never expires.
- R8: After a timeout with the recovery select (ctrl bit 3) at 0, the outputs reload to the table entry of the captured strap code.
- R9: After a timeout with the recovery select at 1, act_n and act_m come from recovery N (address 4) and recovery M (address 5). act_code follows the override as in R4. A write to recovery N or M reloads the outputs while recovery is active.
- R10: Writing ctrl with bit 7 set clears wd_timeout and reloads the normal selection. Changes on the strap pins after capture have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_code | input | CODE_W | Strap pins, captured once after reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 ctrl, 1 select, 2 N, 3 M, 4 recovery N, 5 recovery M) |
| wr_data | input | DATA_W | Write data |
| wr_hold | input | 1 | High while a multi-register transfer is in progress |
| act_n | output | N_W | Active feedback divider value |
| act_m | output | M_W | Active reference divider value |
| act_code | output | CODE_W | Active ratio/gear code |
| load_stb | output | 1 | One-cycle pulse when the active settings change |
| wd_timeout | output | 1 | Sticky watchdog-expired flag, also selects recovery |

## Verification
The hardest state to reach from the ports is recovery with programmed recovery values. It needs the watchdog to be armed by a real change of the active settings, a quiet window long enough for the timer to expire, and then writes during recovery that must not re-arm the timer. The bench first makes a change that leaves the outputs unchanged, so it produces no strobe and no arming. It then writes a new N, measures the exact cycle at which the flag rises, and only afterwards programs the recovery select, the override and the recovery N/M. Finally it clears the flag and checks that the normal selection returns.

// File: rtl/clkfs_pkg.sv
package clkfs_pkg;
   typedef enum logic [2:0] {
      RA_CTRL = 3'd0,
      RA_SEL  = 3'd1,
      RA_N    = 3'd2,
      RA_M    = 3'd3,
      RA_RN   = 3'd4,
      RA_RM   = 3'd5
   } reg_addr_e;

   localparam int CB_PROG  = 0;
   localparam int CB_OVR   = 1;
   localparam int CB_WDEN  = 2;
   localparam int CB_RSEL  = 3;
   localparam int CB_CLR   = 7;
endpackage

// File: rtl/clkfs_regs.sv
module clkfs_regs
   import clkfs_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int N_W    = 8,
   parameter int M_W    = 7,
   parameter int CODE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              prog_en,
   output logic              override,
   output logic              wd_en,
   output logic              rcv_sel,
   output logic [CODE_W-1:0] sel,
   output logic [N_W-1:0]    n_val,
   output logic [M_W-1:0]    m_val,
   output logic [N_W-1:0]    rn_val,
   output logic [M_W-1:0]    rm_val,
   output logic              wr_evt,
   output logic              flag_clr
);
   logic unused_data;
   assign unused_data = ^wr_data;

   assign wr_evt   = wr_en && (wr_addr <= RA_RM);
   assign flag_clr = wr_en && (wr_addr == RA_CTRL) && wr_data[CB_CLR];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prog_en  <= 1'b0;
         override <= 1'b0;
         wd_en    <= 1'b0;
         rcv_sel  <= 1'b0;
         sel      <= '0;
         n_val    <= '0;
         m_val    <= '0;
         rn_val   <= '0;
         rm_val   <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            RA_CTRL: begin
               prog_en  <= wr_data[CB_PROG];
               override <= wr_data[CB_OVR];
               wd_en    <= wr_data[CB_WDEN];
               rcv_sel  <= wr_data[CB_RSEL];
            end
            RA_SEL:  sel    <= wr_data[CODE_W-1:0];
            RA_N:    n_val  <= wr_data[N_W-1:0];
            RA_M:    m_val  <= wr_data[M_W-1:0];
            RA_RN:   rn_val <= wr_data[N_W-1:0];
            RA_RM:   rm_val <= wr_data[M_W-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/clkfs_select.sv
module clkfs_select #(
   parameter int N_W        = 8,
   parameter int M_W        = 7,
   parameter int CODE_W     = 5,
   parameter int TBL_BASE_N = 64,
   parameter int TBL_STEP_N = 2,
   parameter int TBL_M      = 24
) (
   input  logic              prog_en,
   input  logic              override,
   input  logic              rcv_sel,
   input  logic              in_rcv,
   input  logic [CODE_W-1:0] sel,
   input  logic [CODE_W-1:0] strap,
   input  logic [N_W-1:0]    n_val,
   input  logic [M_W-1:0]    m_val,
   input  logic [N_W-1:0]    rn_val,
   input  logic [M_W-1:0]    rm_val,
   output logic [N_W-1:0]    o_n,
   output logic [M_W-1:0]    o_m,
   output logic [CODE_W-1:0] o_code
);
   localparam logic [M_W-1:0] TBL_M_V = M_W'(TBL_M);

   function automatic logic [N_W-1:0] tbl_n(input logic [CODE_W-1:0] c);
      return N_W'(TBL_BASE_N + TBL_STEP_N * int'(c));
   endfunction

   logic [CODE_W-1:0] ratio;
   assign ratio = override ? sel : strap;

   always_comb begin
      if (in_rcv && !rcv_sel) begin
         o_code = strap;
         o_n    = tbl_n(strap);
         o_m    = TBL_M_V;
      end else if (in_rcv) begin
         o_code = ratio;
         o_n    = rn_val;
         o_m    = rm_val;
      end else if (prog_en) begin
         o_code = ratio;
         o_n    = n_val;
         o_m    = m_val;
      end else begin
         o_code = ratio;
         o_n    = tbl_n(ratio);
         o_m    = TBL_M_V;
      end
   end
endmodule

// File: rtl/clkfs_wdog.sv
module clkfs_wdog #(
   parameter int WD_RELOAD   = 5,
   parameter int WD_PRESCALE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic arm,
   input  logic clr,
   output logic expire,
   output logic flag
);
   localparam int CNT_W = $clog2(WD_RELOAD + 1);
   localparam int PRE_W = (WD_PRESCALE > 1) ? $clog2(WD_PRESCALE) : 1;

   logic             running;
   logic             tick;
   logic [CNT_W-1:0] cnt;

   generate
      if (WD_PRESCALE == 1) begin : g_nopre
         assign tick = 1'b1;
      end else begin : g_pre
         logic [PRE_W-1:0] pre;
         assign tick = (pre == PRE_W'(WD_PRESCALE - 1));
         always_ff @(posedge clk) begin
            if (!rst_n || !enable || arm || !running || tick) pre <= '0;
            else                                              pre <= pre + 1'b1;
         end
      end
   endgenerate

   assign expire = running && tick && (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= CNT_W'(WD_RELOAD);
         flag    <= 1'b0;
      end else begin
         if (!enable) begin
            running <= 1'b0;
            cnt     <= CNT_W'(WD_RELOAD);
         end else if (arm) begin
            running <= 1'b1;
            cnt     <= CNT_W'(WD_RELOAD);
         end else if (running && tick) begin
            if (cnt == '0) running <= 1'b0;
            else           cnt     <= cnt - 1'b1;
         end
         if (expire)   flag <= 1'b1;
         else if (clr) flag <= 1'b0;
      end
   end
endmodule

// File: rtl/clkfs_ctrl.sv
module clkfs_ctrl #(
   parameter int DATA_W      = 8,
   parameter int N_W         = 8,
   parameter int M_W         = 7,
   parameter int CODE_W      = 5,
   parameter int TBL_BASE_N  = 64,
   parameter int TBL_STEP_N  = 2,
   parameter int TBL_M       = 24,
   parameter int WD_RELOAD   = 5,
   parameter int WD_PRESCALE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] strap_code,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_hold,
   output logic [N_W-1:0]    act_n,
   output logic [M_W-1:0]    act_m,
   output logic [CODE_W-1:0] act_code,
   output logic              load_stb,
   output logic              wd_timeout
);
   generate
      if (N_W > DATA_W || M_W > DATA_W || CODE_W > DATA_W) begin : g_bad_w
         $error("clkfs_ctrl: field wider than write data");
      end
      if (WD_PRESCALE < 1 || WD_RELOAD < 1) begin : g_bad_wd
         $error("clkfs_ctrl: watchdog parameters must be positive");
      end
      if (TBL_BASE_N + TBL_STEP_N * ((1 << CODE_W) - 1) >= (1 << N_W)) begin : g_bad_tbl
         $error("clkfs_ctrl: table N exceeds N_W");
      end
      if (TBL_M >= (1 << M_W)) begin : g_bad_m
         $error("clkfs_ctrl: table M exceeds M_W");
      end
   endgenerate

   logic              cfg_prog, cfg_ovr, cfg_wd_en, cfg_rcv_sel;
   logic [CODE_W-1:0] cfg_sel;
   logic [N_W-1:0]    cfg_n, cfg_rn;
   logic [M_W-1:0]    cfg_m, cfg_rm;
   logic              wr_evt, flag_clr;
   logic              wd_expire;
   logic [N_W-1:0]    nxt_n;
   logic [M_W-1:0]    nxt_m;
   logic [CODE_W-1:0] nxt_code;
   logic              strap_done;
   logic [CODE_W-1:0] strap_lat;
   logic              pend;
   logic              new_evt, commit;

   clkfs_regs #(.DATA_W(DATA_W), .N_W(N_W), .M_W(M_W), .CODE_W(CODE_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .prog_en(cfg_prog), .override(cfg_ovr), .wd_en(cfg_wd_en), .rcv_sel(cfg_rcv_sel),
      .sel(cfg_sel), .n_val(cfg_n), .m_val(cfg_m), .rn_val(cfg_rn), .rm_val(cfg_rm),
      .wr_evt(wr_evt), .flag_clr(flag_clr)
   );

   clkfs_select #(.N_W(N_W), .M_W(M_W), .CODE_W(CODE_W), .TBL_BASE_N(TBL_BASE_N),
                  .TBL_STEP_N(TBL_STEP_N), .TBL_M(TBL_M)) u_sel (
      .prog_en(cfg_prog), .override(cfg_ovr), .rcv_sel(cfg_rcv_sel), .in_rcv(wd_timeout),
      .sel(cfg_sel), .strap(strap_lat), .n_val(cfg_n), .m_val(cfg_m),
      .rn_val(cfg_rn), .rm_val(cfg_rm), .o_n(nxt_n), .o_m(nxt_m), .o_code(nxt_code)
   );

   clkfs_wdog #(.WD_RELOAD(WD_RELOAD), .WD_PRESCALE(WD_PRESCALE)) u_wdog (
      .clk(clk), .rst_n(rst_n), .enable(cfg_wd_en),
      .arm(load_stb && !wd_timeout), .clr(flag_clr),
      .expire(wd_expire), .flag(wd_timeout)
   );

   assign new_evt = wr_evt || wd_expire || !strap_done;
   assign commit  = pend && !wr_hold;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         strap_done <= 1'b0;
         strap_lat  <= '0;
         pend       <= 1'b0;
         act_n      <= '0;
         act_m      <= '0;
         act_code   <= '0;
         load_stb   <= 1'b0;
      end else begin
         if (!strap_done) begin
            strap_done <= 1'b1;
            strap_lat  <= strap_code;
         end
         load_stb <= 1'b0;
         if (commit) begin
            act_n    <= nxt_n;
            act_m    <= nxt_m;
            act_code <= nxt_code;
            load_stb <= {nxt_n, nxt_m, nxt_code} != {act_n, act_m, act_code};
         end
         pend <= commit ? new_evt : (pend || new_evt);
      end
   end
endmodule

// File: rtl/clkfs_ctrl_chk.sv
module clkfs_ctrl_chk #(
   parameter int N_W    = 8,
   parameter int M_W    = 7,
   parameter int CODE_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_hold,
   input logic [N_W-1:0]    act_n,
   input logic [M_W-1:0]    act_m,
   input logic [CODE_W-1:0] act_code,
   input logic              load_stb,
   input logic              wd_timeout,
   input logic              wd_en,
   input logic              rcv_sel,
   input logic [CODE_W-1:0] strap_lat
);
   assert_stb_means_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load_stb |-> ({act_n, act_m, act_code} != $past({act_n, act_m, act_code})));

   assert_no_silent_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !load_stb |-> $stable({act_n, act_m, act_code}));

   assert_hold_blocks_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hold |=> !load_stb);

   assert_timeout_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wd_timeout) |-> $past(wd_en));

   assert_strap_recovery_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (load_stb && $past(wd_timeout) && !$past(rcv_sel)) |-> (act_code == strap_lat));
endmodule

bind clkfs_ctrl clkfs_ctrl_chk #(.N_W(N_W), .M_W(M_W), .CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_hold(wr_hold), .act_n(act_n), .act_m(act_m),
   .act_code(act_code), .load_stb(load_stb), .wd_timeout(wd_timeout),
   .wd_en(cfg_wd_en), .rcv_sel(cfg_rcv_sel), .strap_lat(strap_lat)
);

// File: tb/clkfs_ctrl_bench.sv
`timescale 1ns/1ps
module clkfs_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] strap_code = 5'd9;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       wr_hold = 1'b0;
   logic [7:0] act_n;
   logic [6:0] act_m;
   logic [4:0] act_code;
   logic       load_stb;
   logic       wd_timeout;

   int errors = 0;
   int checks = 0;
   int stb_seen = 0;
   bit done = 0;

   always #4 clk = ~clk;

   clkfs_ctrl u_clkfs_ctrl (
      .clk(clk), .rst_n(rst_n), .strap_code(strap_code), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_hold(wr_hold), .act_n(act_n),
      .act_m(act_m), .act_code(act_code), .load_stb(load_stb), .wd_timeout(wd_timeout)
   );

   always @(negedge clk) if (rst_n && load_stb) stb_seen++;

   // ctrl, sel, n, m, expected n, expected m, expected code (strap code is 9)
   localparam logic [55:0] VEC [6] = '{
      {8'h00, 8'd3,  8'd100, 8'd10, 8'd82,  8'd24, 8'd9},
      {8'h02, 8'd3,  8'd100, 8'd10, 8'd70,  8'd24, 8'd3},
      {8'h01, 8'd3,  8'd100, 8'd10, 8'd100, 8'd10, 8'd9},
      {8'h03, 8'd17, 8'd200, 8'd33, 8'd200, 8'd33, 8'd17},
      {8'h02, 8'd31, 8'd200, 8'd33, 8'd126, 8'd24, 8'd31},
      {8'h00, 8'd31, 8'd200, 8'd33, 8'd82,  8'd24, 8'd9}
   };

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic chk_out(input string tag, input int n, input int m, input int c);
      chk({tag, " n"}, int'(act_n), n);
      chk({tag, " m"}, int'(act_m), m);
      chk({tag, " code"}, int'(act_code), c);
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int s;
      int k;
      int pn, pm, pc;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 reset n", int'(act_n), 0);
      chk("R1 reset stb", int'(load_stb), 0);
      chk("R1 reset flag", int'(wd_timeout), 0);
      rst_n = 1'b1;
      settle();
      chk_out("R1 R2 after strap capture", 82, 24, 9);
      chk("R1 one strobe after reset", stb_seen, 1);

      // table of vectors, each applied as one held transfer (R2 R3 R4 R6)
      pn = 82; pm = 24; pc = 9;
      for (int i = 0; i < 6; i++) begin
         s = stb_seen;
         wr_hold = 1'b1;
         wr(3'd0, VEC[i][55:48]);
         wr(3'd1, VEC[i][47:40]);
         wr(3'd2, VEC[i][39:32]);
         wr(3'd3, VEC[i][31:24]);
         wr_hold = 1'b0;
         settle();
         chk_out($sformatf("R2 R3 R4 vector %0d", i), int'(VEC[i][23:16]),
                 int'(VEC[i][15:8]), int'(VEC[i][7:0]));
         chk($sformatf("R6 vector %0d strobes", i), stb_seen - s,
             (pn != int'(VEC[i][23:16]) || pm != int'(VEC[i][15:8]) ||
              pc != int'(VEC[i][7:0])) ? 1 : 0);
         pn = int'(VEC[i][23:16]); pm = int'(VEC[i][15:8]); pc = int'(VEC[i][7:0]);
      end

      // R5: single writes reload at once
      s = stb_seen;
      wr(3'd0, 8'h01); settle();
      chk_out("R4 R5 prog enable", 200, 33, 9);
      chk("R5 strobe on ctrl write", stb_seen - s, 1);
      s = stb_seen;
      wr(3'd2, 8'd120); settle();
      chk_out("R5 N alone", 120, 33, 9);
      chk("R5 strobe on N write", stb_seen - s, 1);
      s = stb_seen;
      wr(3'd2, 8'd120); settle();
      chk("R5 no strobe without change", stb_seen - s, 0);

      // R6: held transfer, checked mid-way
      s = stb_seen;
      wr_hold = 1'b1;
      wr(3'd3, 8'd50);
      repeat (2) @(negedge clk);
      chk("R6 held M not applied", int'(act_m), 33);
      chk("R6 no strobe during hold", stb_seen - s, 0);
      wr(3'd2, 8'd121);
      wr_hold = 1'b0;
      settle();
      chk_out("R6 after transfer", 121, 50, 9);
      chk("R6 single strobe", stb_seen - s, 1);

      // R10: strap pins ignored after capture
      strap_code = 5'd4;
      wr(3'd0, 8'h01); settle();
      chk("R10 strap held", int'(act_code), 9);

      // R7: watchdog timing
      s = stb_seen;
      wr(3'd0, 8'h05); settle();
      chk("R7 enable alone no strobe", stb_seen - s, 0);
      chk("R7 not armed without change", int'(wd_timeout), 0);
      wr(3'd2, 8'd120);
      @(negedge clk);
      chk("R7 strobe starts timer", int'(load_stb), 1);
      k = 0;
      while (!wd_timeout && k < 200) begin
         @(negedge clk);
         k++;
      end
      chk("R7 timeout delay", k, 25);
      repeat (2) @(negedge clk);
      chk_out("R8 strap recovery", 82, 24, 9);
      repeat (50) @(negedge clk);
      chk("R7 flag sticky", int'(wd_timeout), 1);
      chk_out("R8 recovery held", 82, 24, 9);

      // R9: programmed recovery
      wr(3'd1, 8'd5);
      wr(3'd4, 8'd150);
      wr(3'd5, 8'd40);
      wr(3'd0, 8'h0F);
      settle();
      chk_out("R9 programmed recovery", 150, 40, 5);
      chk("R9 flag kept", int'(wd_timeout), 1);
      s = stb_seen;
      wr(3'd4, 8'd151); settle();
      chk("R9 recovery N reload", int'(act_n), 151);
      chk("R9 reload strobe", stb_seen - s, 1);

      // R10: clear flag returns to normal selection
      wr(3'd0, 8'h81); settle();
      chk("R10 flag cleared", int'(wd_timeout), 0);
      chk_out("R10 normal selection", 120, 50, 9);

      // R7: disabled watchdog never expires
      wr(3'd2, 8'd122);
      repeat (60) @(negedge clk);
      chk("R7 disabled no timeout", int'(wd_timeout), 0);
      chk("R7 disabled N applied", int'(act_n), 122);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule